// File: doc/BRIEF.md
# Nibble Expression Stack Datapath

This block is the operand-stack datapath of a small stack-based processor core. Items are 4 bits wide. The topmost item sits in a dedicated accumulator register. Every deeper item is kept in a 256-entry nibble memory. An 8-bit pointer always addresses the item directly beneath the top, called the second item in this brief. A decoder in front of the block issues one command per cycle on the command port. The block answers with the current top value, the pointer, and two condition flags: carry/borrow and a zero-result "branch" flag.

Because the top item is held apart from the memory, every push and every pop moves one nibble between the register and the memory. A push writes the old top value into memory one slot above the pointer, advances the pointer, and loads the new value into the register. A pop does the reverse. Two-operand ALU commands combine the second item with the top item, write the result into the register, and release the second item's slot, all in the same cycle. Shift and rotate commands work on the top item alone. Every command takes effect at the clock edge that samples it. The internal classification of commands (hold, push, pop, binary, unary) is decoded fresh each cycle. There are no sequencing states beyond the datapath registers themselves.

Top module: `nstk_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sp_o` equals `SP_RESET` (default 0), and `tos_o`, `carry_o` and `branch_o` are all 0.
- R2: Push (`cmd_op`=1): the old top value is written into memory at `sp_o`+1. The pointer becomes `sp_o`+1 and `tos_o` becomes `cmd_data`, with one cycle of latency.
- R3: Pop (`cmd_op`=2): `tos_o` takes the memory item at the current pointer, and the pointer then decreases by one.
- R4: The pointer wraps modulo 256 in both directions: a push at 255 gives 0, and a pop at 0 gives 255.
- R5: ADD (`cmd_op`=3): `tos_o` becomes (second + top) mod 16. `carry_o` becomes 1 exactly when the sum exceeds 15. The pointer decreases by one.
- R6: SUB (`cmd_op`=4): `tos_o` becomes (second − top) mod 16. `carry_o` is the borrow, which is 1 exactly when second < top. The pointer decreases by one.
- R7: AND/OR/XOR (`cmd_op`=5/6/7): `tos_o` becomes the bitwise result of second and top. The pointer decreases by one. `carry_o` is unchanged.
- R8: SHL/SHR (`cmd_op`=8/9): the top value is shifted by one bit with a 0 entering. The bit shifted out goes to `carry_o`, and the pointer is unchanged.
- R9: ROL/ROR (`cmd_op`=10/11): a 5-bit rotate through `carry_o`. ROL gives top = {top[2:0], carry} and carry = top[3]. ROR gives top = {carry, top[3:1]} and carry = top[0]. The pointer is unchanged.
- R10: After every ALU command (opcodes 3 to 11), `branch_o` is 1 exactly when the new top value is zero. Push and pop leave both flags unchanged.
- R11: With `cmd_valid` low, with NOP (`cmd_op`=0), or with an unused opcode (12 to 15), the top value, pointer and flags are all unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code (see requirements) |
| cmd_data | input | DW (4) | Value loaded by a push |
| tos_o | output | DW (4) | Top-of-stack register |
| carry_o | output | 1 | Carry/borrow flag |
| branch_o | output | 1 | Zero-result flag |
| sp_o | output | AW (8) | Pointer to the second item |

## Verification
Every result, whether top value, pointer or either flag, is registered once. It is therefore due on the first rising edge after the command is presented. A command that reads the second item sees memory contents written by earlier commands with no extra delay, because the memory read is combinational. The bench drives each command on a falling edge and samples all four outputs on the next falling edge. This is half a period after the edge that applies the command and before the next command is applied. The bench first fills all 256 slots so that every pop reads a known value. It then sweeps all 256 operand pairs for each two-operand command, and all 16 values times both carry inputs for each single-operand command.

// File: rtl/nstk_pkg.sv
package nstk_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_PUSH = 4'd1,
        OP_POP  = 4'd2,
        OP_ADD  = 4'd3,
        OP_SUB  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_ROL  = 4'd10,
        OP_ROR  = 4'd11
    } op_e;

    typedef enum logic [2:0] {
        KIND_HOLD,
        KIND_PUSH,
        KIND_POP,
        KIND_BIN,
        KIND_UNI
    } kind_e;

endpackage

// File: rtl/nstk_dec.sv
module nstk_dec (
    input  logic                cmd_valid,
    input  logic [3:0]          cmd_op,
    output nstk_pkg::kind_e     kind
);
    import nstk_pkg::*;

    always_comb begin
        kind = KIND_HOLD;
        if (cmd_valid) begin
            unique case (op_e'(cmd_op))
                OP_PUSH:                        kind = KIND_PUSH;
                OP_POP:                         kind = KIND_POP;
                OP_ADD, OP_SUB,
                OP_AND, OP_OR, OP_XOR:          kind = KIND_BIN;
                OP_SHL, OP_SHR,
                OP_ROL, OP_ROR:                 kind = KIND_UNI;
                default:                        kind = KIND_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/nstk_alu.sv
module nstk_alu #(
    parameter int DW = 4
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] nos,
    input  logic [DW-1:0] tos,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          zero
);
    import nstk_pkg::*;

    logic [DW:0] sum_w;
    logic [DW:0] dif_w;

    always_comb begin
        sum_w = {1'b0, nos} + {1'b0, tos};
        dif_w = {1'b0, nos} - {1'b0, tos};
        res   = tos;
        cout  = cin;
        unique case (op_e'(op))
            OP_ADD: {cout, res} = sum_w;
            OP_SUB: {cout, res} = dif_w;
            OP_AND: res = nos & tos;
            OP_OR:  res = nos | tos;
            OP_XOR: res = nos ^ tos;
            OP_SHL: begin res = {tos[DW-2:0], 1'b0}; cout = tos[DW-1]; end
            OP_SHR: begin res = {1'b0, tos[DW-1:1]}; cout = tos[0];    end
            OP_ROL: begin res = {tos[DW-2:0], cin};  cout = tos[DW-1]; end
            OP_ROR: begin res = {cin, tos[DW-1:1]};  cout = tos[0];    end
            default: begin res = tos; cout = cin; end
        endcase
        zero = (res == '0);
    end

endmodule

// File: rtl/nstk_ram.sv
module nstk_ram #(
    parameter int DW = 4,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/nstk_core.sv
module nstk_core #(
    parameter int          DW       = 4,
    parameter int          AW       = 8,
    parameter logic [7:0]  SP_RESET = 8'd0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    output logic [DW-1:0] tos_o,
    output logic          carry_o,
    output logic          branch_o,
    output logic [AW-1:0] sp_o
);
    import nstk_pkg::*;

    localparam logic [AW-1:0] SP_INIT = AW'(SP_RESET);

    kind_e         kind;
    logic [AW-1:0] sp_q;
    logic [AW-1:0] sp_inc;
    logic [AW-1:0] sp_dec;
    logic [DW-1:0] tos_q;
    logic          carry_q;
    logic          branch_q;
    logic [DW-1:0] nos_rd;
    logic [DW-1:0] alu_res;
    logic          alu_c;
    logic          alu_z;

    assign sp_inc = sp_q + 1'b1;
    assign sp_dec = sp_q - 1'b1;

    nstk_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .kind      (kind)
    );

    nstk_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (kind == KIND_PUSH),
        .waddr (sp_inc),
        .wdata (tos_q),
        .raddr (sp_q),
        .rdata (nos_rd)
    );

    nstk_alu #(.DW(DW)) u_alu (
        .op   (cmd_op),
        .nos  (nos_rd),
        .tos  (tos_q),
        .cin  (carry_q),
        .res  (alu_res),
        .cout (alu_c),
        .zero (alu_z)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q     <= SP_INIT;
            tos_q    <= '0;
            carry_q  <= 1'b0;
            branch_q <= 1'b0;
        end else begin
            unique case (kind)
                KIND_HOLD: ;
                KIND_PUSH: begin
                    sp_q  <= sp_inc;
                    tos_q <= cmd_data;
                end
                KIND_POP: begin
                    tos_q <= nos_rd;
                    sp_q  <= sp_dec;
                end
                KIND_BIN: begin
                    tos_q    <= alu_res;
                    carry_q  <= alu_c;
                    branch_q <= alu_z;
                    sp_q     <= sp_dec;
                end
                KIND_UNI: begin
                    tos_q    <= alu_res;
                    carry_q  <= alu_c;
                    branch_q <= alu_z;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tos_o    = tos_q;
        carry_o  = carry_q;
        branch_o = branch_q;
        sp_o     = sp_q;
    end

endmodule

// File: rtl/nstk_chk.sv
module nstk_chk #(
    parameter int DW = 4,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [3:0]    cmd_op,
    input logic [DW-1:0] cmd_data,
    input logic [DW-1:0] tos_o,
    input logic          carry_o,
    input logic          branch_o,
    input logic [AW-1:0] sp_o
);
    logic c_push, c_pop, c_bin, c_uni, c_alu;

    assign c_push = cmd_valid && (cmd_op == 4'd1);
    assign c_pop  = cmd_valid && (cmd_op == 4'd2);
    assign c_bin  = cmd_valid && (cmd_op >= 4'd3) && (cmd_op <= 4'd7);
    assign c_uni  = cmd_valid && (cmd_op >= 4'd8) && (cmd_op <= 4'd11);
    assign c_alu  = c_bin || c_uni;

    AST_PUSH_SP: assert property (@(posedge clk) disable iff (!rst_n)
        c_push |=> sp_o == AW'($past(sp_o) + 1'b1));                       // R2
    AST_PUSH_TOS: assert property (@(posedge clk) disable iff (!rst_n)
        c_push |=> tos_o == $past(cmd_data));                              // R2
    AST_POP_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_pop || c_bin) |=> sp_o == AW'($past(sp_o) - 1'b1));             // R3
    AST_UNARY_SP: assert property (@(posedge clk) disable iff (!rst_n)
        c_uni |=> $stable(sp_o));                                          // R8
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        c_alu |=> branch_o == (tos_o == '0));                              // R10
    AST_MOVE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_push || c_pop) |=> ($stable(carry_o) && $stable(branch_o)));    // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(tos_o) && $stable(sp_o)
                        && $stable(carry_o) && $stable(branch_o)));        // R11

endmodule

bind nstk_core nstk_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .tos_o     (tos_o),
    .carry_o   (carry_o),
    .branch_o  (branch_o),
    .sp_o      (sp_o)
);

// File: tb/tb_nstk_core.sv
`timescale 1ns/1ps
module tb_nstk_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic [3:0] cmd_data = 4'd0;
    logic [3:0] tos_o;
    logic       carry_o;
    logic       branch_o;
    logic [7:0] sp_o;

    int errors = 0;
    int checks = 0;

    int m [256];
    int msp = 0, mtos = 0, mc = 0, mb = 0;

    always #2.5 clk = ~clk;

    nstk_core dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .tos_o(tos_o), .carry_o(carry_o),
        .branch_o(branch_o), .sp_o(sp_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(tag, "tos",    int'(tos_o),    mtos);
        chk(tag, "sp",     int'(sp_o),     msp);
        chk(tag, "carry",  int'(carry_o),  mc);
        chk(tag, "branch", int'(branch_o), mb);
    endtask

    // Expected-state update, computed from the requirement formulas
    task automatic model(input int op, input int d);
        int nos, r;
        nos = m[msp];
        r = mtos;
        case (op)
            1: begin msp = (msp + 1) % 256; m[msp] = mtos; mtos = d; end
            2: begin mtos = nos; msp = (msp + 255) % 256; end
            3: begin r = (nos + mtos) % 16; mc = (nos + mtos > 15) ? 1 : 0; end
            4: begin r = (nos - mtos + 16) % 16; mc = (nos < mtos) ? 1 : 0; end
            5: r = nos & mtos;
            6: r = nos | mtos;
            7: r = nos ^ mtos;
            8: begin r = (mtos * 2) % 16; mc = mtos / 8; end
            9: begin r = mtos / 2; mc = mtos % 2; end
            10: begin r = (mtos * 2) % 16 + mc; mc = mtos / 8; end
            11: begin r = mtos / 2 + 8 * mc; mc = mtos % 2; end
            default: ;
        endcase
        if (op >= 3 && op <= 11) begin
            mtos = r;
            mb = (r == 0) ? 1 : 0;
            if (op <= 7) msp = (msp + 255) % 256;
        end
    endtask

    // Called just after a falling edge; returns just after the next one
    task automatic issue(input int op, input int d);
        cmd_valid = 1'b1;
        cmd_op    = 4'(op);
        cmd_data  = 4'(d);
        @(negedge clk);
        cmd_valid = 1'b0;
        model(op, d);
    endtask

    function automatic string op_tag(input int op);
        case (op)
            3: return "R5 R10";
            4: return "R6 R10";
            5, 6, 7: return "R7 R10";
            8, 9: return "R8 R10";
            default: return "R9 R10";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state, during and after reset
        repeat (3) @(negedge clk);
        chk_state("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1");

        // R2, R4: fill every slot; pointer wraps 255 -> 0
        for (int i = 0; i < 256; i++) begin
            issue(1, i % 16);
            chk_state((i == 255) ? "R4" : "R2");
        end

        // R3, R4: pop from 0 wraps to 255, then more pops
        for (int i = 0; i < 4; i++) begin
            issue(2, 0);
            chk_state((i == 0) ? "R4" : "R3");
        end

        // R5..R7: every operand pair for each two-operand command
        for (int op = 3; op <= 7; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    issue(1, a);
                    issue(1, b);
                    issue(op, 0);
                    chk_state(op_tag(op));
                end
            end
        end

        // R8, R9: every value with both carry inputs for each one-operand command
        for (int op = 8; op <= 11; op++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a < 16; a++) begin
                    issue(1, 15);
                    issue(1, c);
                    issue(3, 0);
                    issue(1, a);
                    chk(op_tag(op), "carry kept by push", int'(carry_o), c);
                    issue(op, 0);
                    chk_state(op_tag(op));
                end
            end
        end

        // R10: push and pop keep a set branch flag and carry
        issue(1, 6);
        issue(1, 6);
        issue(7, 0);
        chk("R10", "branch after zero xor", int'(branch_o), 1);
        issue(1, 3);
        chk_state("R10");
        issue(2, 0);
        chk_state("R10");

        // R11: invalid command, NOP and unused opcodes have no effect
        cmd_valid = 1'b0;
        cmd_op    = 4'd1;
        cmd_data  = 4'd9;
        repeat (2) @(negedge clk);
        chk_state("R11");
        cmd_op = 4'd3;
        repeat (2) @(negedge clk);
        chk_state("R11");
        issue(0, 5);
        chk_state("R11");
        for (int op = 12; op < 16; op++) begin
            issue(op, 7);
            chk_state("R11");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule